// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each byte goes into a transmit queue. A serializer takes the bytes out of the queue one at a time. It sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period. The line rests high between frames. When the queue holds more data at the end of a stop period, the next frame starts at once.

All bit timing comes from a tick that runs at sixteen times the bit rate. A programmable divider produces this tick by dividing the clock by the divisor plus two. The stop period is counted in ticks rather than in whole bits, so a stop period of one and a half bits is possible. When the queue drains, the block raises a one-clock interrupt pulse. A break input holds the line low for as long as it is held.

Top module: `sertx_top`

## Requirements
- R1: During and after synchronous reset, `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0 and `empty_irq` is 0.
- R2: A frame is one low start bit, then the data bits with the least significant bit first, then the optional parity bit, then a high stop period. When the serializer is idle and no break is requested, `txd` is high.
- R3: `len_sel` selects the character length as 5 + `len_sel`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `wr_data` above the selected length are not sent.
- R4: `par_sel` selects the parity. 01 is even parity, and the parity bit equals the XOR of the sent data bits. 10 is odd parity, and the parity bit is the inverse of that XOR. 00 and 11 send no parity bit.
- R5: The stop period is 16 ticks when `stop_long` is 0. When `stop_long` is 1 it is 24 ticks (1.5 bits) for 5-bit characters and 32 ticks (2 bits) for longer characters. When the queue holds data, the next start bit begins right after the stop period. Consecutive frames therefore start exactly (1 + bits + parity) × 16 × (divisor + 2) + stop_ticks × (divisor + 2) clocks apart.
- R6: One bit lasts 16 × (`divisor` + 2) clock cycles.
- R7: The queue holds 64 bytes. `fifo_full` is 1 while it holds 64 bytes. A write while it is full is dropped and never sent.
- R8: `empty_irq` is high for exactly one clock when the queue goes from holding data to empty. It is never high while the queue holds data.
- R9: While `brk` is 1, `txd` is 0 starting one clock after `brk` is sampled. When `brk` returns to 0, the line returns to the serializer's level one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one byte into the transmit queue |
| wr_data | input | 8 | Byte to write |
| len_sel | input | 2 | Character length select (5 + value) |
| par_sel | input | 2 | Parity select: 01 even, 10 odd, else none |
| stop_long | input | 1 | Long stop period (1.5 bits for 5-bit characters, 2 bits otherwise) |
| divisor | input | 16 | Bit-rate divisor; tick period is divisor + 2 clocks |
| brk | input | 1 | Hold the line low while high |
| txd | output | 1 | Serial output, idle high |
| fifo_full | output | 1 | Queue holds 64 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| empty_irq | output | 1 | One-clock pulse when the queue drains |

## Verification
The bench builds the block with its default parameters: a 64-entry queue and a 16-bit divisor. It drives divisors from 0 to 3. These short bit times make it practical to fill the queue completely and push past full within the run, and to measure the spacing of back-to-back frames to the exact clock. That spacing covers every stop length, including the 24-tick stop used only with 5-bit characters. Formats come partly from a directed list and partly from a fixed-seed random draw, so every length, parity and stop choice appears at least once.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;
    localparam int TICKS_PER_BIT = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } ser_state_t;

    typedef struct packed {
        logic [1:0] len_sel;
        logic [1:0] par_sel;
        logic       stop_long;
    } fmt_t;

    // index of the last data bit: 4 .. 7
    function automatic logic [2:0] last_idx(input fmt_t f);
        return 3'd4 + {1'b0, f.len_sel};
    endfunction

    function automatic logic par_on(input fmt_t f);
        return (f.par_sel == 2'b01) || (f.par_sel == 2'b10);
    endfunction

    // length of the stop period in 16x ticks
    function automatic logic [5:0] stop_ticks(input fmt_t f);
        if (!f.stop_long)
            return 6'd16;
        else if (f.len_sel == 2'b00)
            return 6'd24;
        else
            return 6'd32;
    endfunction

    function automatic logic par_bit(input fmt_t f, input logic [CHAR_W-1:0] d);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (3'(i) <= last_idx(f))
                acc = acc ^ d[i];
        end
        return (f.par_sel == 2'b10) ? ~acc : acc;
    endfunction

endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W:0] cnt;
    logic [DIV_W:0] lim;

    assign lim = {1'b0, divisor} + (DIV_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + (DIV_W+1)'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr)
                wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            if (do_rd)
                rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    ser_state_t        state;
    logic [5:0]        tcnt;
    logic [2:0]        bidx;
    logic [CHAR_W-1:0] sh;
    logic              pbit;
    logic              bit_end;
    logic              stop_end;

    assign bit_end  = (tcnt == 6'(TICKS_PER_BIT - 1));
    assign stop_end = (tcnt == stop_ticks(fmt) - 6'd1);
    assign pop      = tick && !fifo_empty &&
                      ((state == S_IDLE) || (state == S_STOP && stop_end));
    assign busy     = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            line  <= 1'b1;
        end else if (tick) begin
            if (pop) begin
                state <= S_START;
                tcnt  <= '0;
                bidx  <= '0;
                sh    <= fifo_data;
                pbit  <= par_bit(fmt, fifo_data);
                line  <= 1'b0;
            end else begin
                case (state)
                    S_START: begin
                        if (bit_end) begin
                            tcnt  <= '0;
                            state <= S_DATA;
                            line  <= sh[0];
                        end else
                            tcnt <= tcnt + 6'd1;
                    end
                    S_DATA: begin
                        if (bit_end) begin
                            tcnt <= '0;
                            if (bidx == last_idx(fmt)) begin
                                if (par_on(fmt)) begin
                                    state <= S_PAR;
                                    line  <= pbit;
                                end else begin
                                    state <= S_STOP;
                                    line  <= 1'b1;
                                end
                            end else begin
                                bidx <= bidx + 3'd1;
                                sh   <= {1'b0, sh[CHAR_W-1:1]};
                                line <= sh[1];
                            end
                        end else
                            tcnt <= tcnt + 6'd1;
                    end
                    S_PAR: begin
                        if (bit_end) begin
                            tcnt  <= '0;
                            state <= S_STOP;
                            line  <= 1'b1;
                        end else
                            tcnt <= tcnt + 6'd1;
                    end
                    S_STOP: begin
                        if (stop_end) begin
                            tcnt  <= '0;
                            state <= S_IDLE;
                        end else
                            tcnt <= tcnt + 6'd1;
                    end
                    default: begin
                        tcnt <= '0;
                        line <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       len_sel,
    input  logic [1:0]       par_sel,
    input  logic             stop_long,
    input  logic [DIV_W-1:0] divisor,
    input  logic             brk,
    output logic             txd,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             empty_irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    fmt_t              fmt;
    logic              tick;
    logic              pop;
    logic              line;
    logic              ser_busy;
    logic [CHAR_W-1:0] head;
    logic [CW-1:0]     fifo_count;
    logic              empty_prev;

    assign fmt = '{len_sel: len_sel, par_sel: par_sel, stop_long: stop_long};

    sertx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (tick)
    );

    sertx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .count   (fifo_count)
    );

    sertx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fmt        (fmt),
        .fifo_empty (fifo_empty),
        .fifo_data  (head),
        .pop        (pop),
        .line       (line),
        .busy       (ser_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            txd        <= 1'b1;
            empty_prev <= 1'b1;
        end else begin
            txd        <= line & ~brk;
            empty_prev <= fifo_empty;
        end
    end

    assign empty_irq = fifo_empty & ~empty_prev;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          brk,
    input logic          txd,
    input logic          empty_irq,
    input logic          fifo_empty,
    input logic          busy,
    input logic [CW-1:0] count
);
    // R9
    brk_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(brk) |-> !txd);

    // R8
    irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
        empty_irq |-> fifo_empty);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        empty_irq |=> !empty_irq);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && !$past(brk)) |-> txd);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> !txd);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .brk        (brk),
    .txd        (txd),
    .empty_irq  (empty_irq),
    .fifo_empty (fifo_empty),
    .busy       (ser_busy),
    .count      (fifo_count)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  len_sel = '0;
    logic [1:0]  par_sel = '0;
    logic        stop_long = 1'b0;
    logic [15:0] divisor = '0;
    logic        brk = 1'b0;
    logic        txd, fifo_full, fifo_empty, empty_irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int irq_cnt = 0;
    logic [7:0] expq [$];

    sertx_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .len_sel(len_sel), .par_sel(par_sel), .stop_long(stop_long),
        .divisor(divisor), .brk(brk), .txd(txd), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .empty_irq(empty_irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (empty_irq) irq_cnt <= irq_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits();
        return 5 + int'(len_sel);
    endfunction

    function automatic bit has_par();
        return (par_sel == 2'b01) || (par_sel == 2'b10);
    endfunction

    function automatic int stop_len();
        if (!stop_long) return 16;
        return (len_sel == 2'b00) ? 24 : 32;
    endfunction

    function automatic logic [7:0] mask_of();
        return 8'(int'((1 << nbits()) - 1));
    endfunction

    function automatic logic exp_par(input logic [7:0] d);
        logic x;
        x = ^(d & mask_of());
        return (par_sel == 2'b10) ? ~x : x;
    endfunction

    function automatic int frame_gap();
        int t;
        t = int'(divisor) + 2;
        return (1 + nbits() + (has_par() ? 1 : 0)) * 16 * t + stop_len() * t;
    endfunction

    task automatic get_frame(output logic [7:0] d, output logic pb, output int sc);
        int p;
        p = 16 * (int'(divisor) + 2);
        d = '0;
        pb = 1'b0;
        do @(negedge clk); while (txd !== 1'b0);
        sc = cyc;
        repeat (p / 2) @(negedge clk);
        check("R2 start bit", int'(txd), 0);
        for (int i = 0; i < nbits(); i++) begin
            repeat (p) @(negedge clk);
            d[i] = txd;
        end
        if (has_par()) begin
            repeat (p) @(negedge clk);
            pb = txd;
        end
        repeat (p) @(negedge clk);
        check("R2 stop level", int'(txd), 1);
    endtask

    task automatic run_burst(input logic [1:0] ls, input logic [1:0] ps,
                             input logic sl, input int dv, input int n);
        int irq0;
        @(negedge clk);
        len_sel = ls; par_sel = ps; stop_long = sl; divisor = 16'(dv);
        expq.delete();
        for (int i = 0; i < n; i++) expq.push_back(8'($urandom));
        irq0 = irq_cnt;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    @(negedge clk);
                    wr_en = 1'b1;
                    wr_data = expq[i];
                end
                @(negedge clk);
                wr_en = 1'b0;
            end
            begin
                int prev_sc;
                prev_sc = 0;
                for (int i = 0; i < n; i++) begin
                    logic [7:0] d;
                    logic pb;
                    int sc;
                    get_frame(d, pb, sc);
                    check("R3 data bits", int'(d), int'(expq[i] & mask_of()));
                    if (has_par())
                        check("R4 parity bit", int'(pb), int'(exp_par(expq[i])));
                    if (i > 0)
                        check("R5 R6 frame spacing", sc - prev_sc, frame_gap());
                    prev_sc = sc;
                end
            end
        join
        repeat (40 * (dv + 2)) @(negedge clk);
        check("R8 one irq per drain", irq_cnt - irq0, 1);
        check("R2 idle high", int'(txd), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1 during reset
        check("R1 txd in reset", int'(txd), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd", int'(txd), 1);
        check("R1 empty", int'(fifo_empty), 1);
        check("R1 full", int'(fifo_full), 0);
        check("R1 irq", int'(empty_irq), 0);
        repeat (10) @(negedge clk);
        check("R1 no irq after reset", irq_cnt, 0);

        // directed formats
        run_burst(2'b00, 2'b00, 1'b0, 0, 4);   // 5 bits, 1 stop
        run_burst(2'b00, 2'b01, 1'b1, 0, 4);   // 5 bits even, 1.5 stop
        run_burst(2'b11, 2'b10, 1'b1, 0, 4);   // 8 bits odd, 2 stop
        run_burst(2'b01, 2'b11, 1'b0, 3, 3);   // 6 bits, code 11 no parity
        run_burst(2'b10, 2'b01, 1'b0, 1, 4);   // 7 bits even
        run_burst(2'b01, 2'b10, 1'b1, 2, 3);   // 6 bits odd, 2 stop

        // random formats
        for (int k = 0; k < 5; k++)
            run_burst(2'($urandom), 2'($urandom), 1'($urandom),
                      int'($urandom_range(0, 2)), int'($urandom_range(3, 6)));

        // R7: fill past capacity; first byte leaves, 64 stored, last dropped
        @(negedge clk);
        len_sel = 2'b11; par_sel = 2'b00; stop_long = 1'b0; divisor = 16'd0;
        expq.delete();
        for (int i = 0; i < 66; i++) expq.push_back(8'($urandom));
        fork
            begin
                for (int i = 0; i < 66; i++) begin
                    @(negedge clk);
                    wr_en = 1'b1;
                    wr_data = expq[i];
                end
                @(negedge clk);
                wr_en = 1'b0;
                check("R7 full flag", int'(fifo_full), 1);
            end
            begin
                for (int i = 0; i < 65; i++) begin
                    logic [7:0] d;
                    logic pb;
                    int sc;
                    get_frame(d, pb, sc);
                    check("R7 queued data", int'(d), int'(expq[i]));
                end
            end
        join
        repeat (400) @(negedge clk);
        check("R7 dropped write not sent", int'(txd), 1);
        check("R7 empty after drain", int'(fifo_empty), 1);

        // R9 break
        @(negedge clk);
        brk = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 break low", int'(txd), 0);
        repeat (200) @(negedge clk);
        check("R9 break held", int'(txd), 0);
        brk = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 release", int'(txd), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule